// File: doc/BRIEF.md
# Dual-Pipe Latency-Aware Operand Bypass Network

This block chooses the source operands for a dual-issue, in-order pipeline with two execution pipes, called even and odd. Each pipe holds one operation per stage. Every stage entry reports a valid bit, a destination register, an execution-unit identifier (1 to 7, with 0 meaning an empty slot) and the number of cycles since that operation began execution. The entry also carries its 128-bit result value.

For every source operand of the two operations entering execution, the block searches the in-flight entries of both pipes. It looks for the youngest live entry that writes the requested register. If that entry's unit latency has elapsed, the block forwards its value. If the entry is still computing, the block raises a stall for the consumer's pipe. If no entry matches, the register-file value passes through. Results that have already been written back are not visible here, because the one-cycle register-file read already returns them.

The block is purely combinational. The surrounding pipeline owns the stage registers and the register file. It consumes the stall signals and the selected operands in the same cycle.

Top module: `fwd_net`

## Requirements
- R1: A stage entry whose valid bit is 0, or whose unit identifier is 0, never supplies a forwarded value and never causes a stall.
- R2: A live entry supplies an operand only when its destination register equals the operand's source register. An entry in any stage of either pipe can feed operands of either pipe.
- R3: An entry is ready when its elapsed-cycle count is at least the latency of its unit. The default latencies for units 1..7 are 2, 4, 6, 4, 4, 6 and 7, so a unit-1 (simple fixed-point) result is first forwarded at elapsed count 2.
- R4: When several live entries match, the youngest one decides. A lower stage index is younger. Within one stage, the odd-pipe entry is younger than the even-pipe entry.
- R5: When the deciding entry is not ready, the stall of the consumer's pipe is 1 and the operand output equals the register-file value. An older ready match is never used in that case.
- R6: When no live entry matches, the operand equals the register-file value and that operand causes no stall.
- R7: Register 0 is matched like any other register, and forwarded 128-bit values appear on the operand output bit for bit.
- R8: Operand slots 0..NSRC-1 belong to the even pipe and drive only `stall_ev`. Slots NSRC..2*NSRC-1 belong to the odd pipe and drive only `stall_od`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ev_vld | input | NST | Even pipe: valid bit per stage (stage 0 youngest) |
| ev_dst | input | NST*RW | Even pipe: destination register per stage |
| ev_unit | input | NST*3 | Even pipe: execution-unit identifier per stage |
| ev_age | input | NST*CW | Even pipe: cycles since execution began, per stage |
| ev_data | input | NST*DW | Even pipe: result value per stage |
| od_vld | input | NST | Odd pipe: valid bit per stage |
| od_dst | input | NST*RW | Odd pipe: destination register per stage |
| od_unit | input | NST*3 | Odd pipe: execution-unit identifier per stage |
| od_age | input | NST*CW | Odd pipe: cycles since execution began, per stage |
| od_data | input | NST*DW | Odd pipe: result value per stage |
| src_addr | input | 2*NSRC*RW | Source register of each operand slot |
| rf_data | input | 2*NSRC*DW | Register-file value of each operand slot |
| opnd | output | 2*NSRC*DW | Selected value of each operand slot |
| stall_ev | output | 1 | Even-pipe consumer must wait |
| stall_od | output | 1 | Odd-pipe consumer must wait |

## Verification
The bench builds the block with its defaults: seven stages per pipe, three operand slots per pipe, 7-bit register numbers, 128-bit data, a 4-bit age field and the latency set 2, 4, 6, 4, 4, 6, 7. The 4-bit age lets elapsed counts run past the longest latency, so ready and not-ready are both reachable for every unit. The random vectors draw register numbers from a narrow range. Many entries therefore match the same source at once, and this exercises the youngest-wins order across stages and between the two pipes. Directed vectors cover the boundary one below and at each unit's latency. They also cover the case where a young unready match shadows an older ready one.

// File: rtl/fwd_pkg.sv
// Package: shared unit-identifier type for the bypass network.
// Assumes at most seven execution units; identifier 0 marks an empty slot.
package fwd_pkg;
    localparam int UNIT_W    = 3;
    localparam int NUM_UNITS = 7;
    typedef logic [UNIT_W-1:0] unit_id_t;
    localparam unit_id_t UNIT_NONE = '0;
endpackage

// File: rtl/fwd_lat_lut.sv
// Module: fwd_lat_lut
// Decides whether one stage entry is live and whether its result is ready.
// Assumes the elapsed count is supplied by the pipeline and latencies are >= 1.
module fwd_lat_lut
    import fwd_pkg::*;
#(
    parameter int CW   = 4,
    parameter int LAT1 = 2,
    parameter int LAT2 = 4,
    parameter int LAT3 = 6,
    parameter int LAT4 = 4,
    parameter int LAT5 = 4,
    parameter int LAT6 = 6,
    parameter int LAT7 = 7
) (
    input  logic          vld,
    input  unit_id_t      unit,
    input  logic [CW-1:0] age,
    output logic          live,
    output logic          rdy
);
    localparam int LAT_TAB [0:7] = '{0, LAT1, LAT2, LAT3, LAT4, LAT5, LAT6, LAT7};

    // Purpose: qualify the entry and compare its age against its unit latency.
    always_comb begin
        live = vld && (unit != UNIT_NONE);
        rdy  = live && (int'(age) >= LAT_TAB[unit]);
    end

    // Purpose: an empty or invalid slot is never ready.
    always_comb begin
        if (!vld || unit == UNIT_NONE)
            assert_idle_slot_R1: assert (!rdy) else $error("idle slot reported ready");
    end

    // Purpose: no unit becomes ready before execution has advanced one cycle.
    always_comb begin
        if (rdy)
            assert_min_age_R3: assert (int'(age) >= 1) else $error("ready at age 0");
    end
endmodule

// File: rtl/fwd_pick.sv
// Module: fwd_pick
// Selects one operand from age-ordered entries (index 0 youngest) or the register file.
// Assumes entries arrive already qualified (live/rdy) and ordered by program age.
module fwd_pick #(
    parameter int NENT = 14,
    parameter int RW   = 7,
    parameter int DW   = 128,
    localparam int IW  = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic [NENT-1:0]    live,
    input  logic [NENT-1:0]    rdy,
    input  logic [NENT*RW-1:0] dst,
    input  logic [NENT*DW-1:0] data,
    input  logic [RW-1:0]      src,
    input  logic [DW-1:0]      rf,
    output logic [DW-1:0]      opnd,
    output logic               pend
);
    logic          found;
    logic [IW-1:0] idx;

    // Purpose: scan oldest to youngest so the youngest match is the last kept.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = NENT - 1; k >= 0; k--) begin
            if (live[k] && (dst[k*RW +: RW] == src)) begin
                found = 1'b1;
                idx   = IW'(k);
            end
        end
    end

    // Purpose: forward a ready winner, otherwise pass the register-file value.
    always_comb begin
        pend = found && !rdy[idx];
        opnd = (found && rdy[idx]) ? data[idx*DW +: DW] : rf;
    end

    // Purpose: a pending winner must not leak any bypassed value.
    always_comb begin
        if (pend)
            assert_pend_uses_rf_R5: assert (opnd == rf) else $error("stalled operand not from rf");
    end

    // Purpose: with no match the register file is used and nothing stalls.
    always_comb begin
        if (!found)
            assert_miss_uses_rf_R6: assert (opnd == rf && !pend) else $error("miss did not use rf");
    end
endmodule

// File: rtl/fwd_net.sv
// Module: fwd_net (top)
// Operand bypass for two in-order pipes with per-unit result latency.
// Assumes stage 0 is the youngest stage and that, within a stage, the odd-pipe
// operation follows the even-pipe one in program order. Purely combinational.
module fwd_net
    import fwd_pkg::*;
#(
    parameter int NST  = 7,
    parameter int NSRC = 3,
    parameter int RW   = 7,
    parameter int DW   = 128,
    parameter int CW   = 4,
    parameter int LAT1 = 2,
    parameter int LAT2 = 4,
    parameter int LAT3 = 6,
    parameter int LAT4 = 4,
    parameter int LAT5 = 4,
    parameter int LAT6 = 6,
    parameter int LAT7 = 7
) (
    input  logic [NST-1:0]        ev_vld,
    input  logic [NST*RW-1:0]     ev_dst,
    input  logic [NST*3-1:0]      ev_unit,
    input  logic [NST*CW-1:0]     ev_age,
    input  logic [NST*DW-1:0]     ev_data,
    input  logic [NST-1:0]        od_vld,
    input  logic [NST*RW-1:0]     od_dst,
    input  logic [NST*3-1:0]      od_unit,
    input  logic [NST*CW-1:0]     od_age,
    input  logic [NST*DW-1:0]     od_data,
    input  logic [2*NSRC*RW-1:0]  src_addr,
    input  logic [2*NSRC*DW-1:0]  rf_data,
    output logic [2*NSRC*DW-1:0]  opnd,
    output logic                  stall_ev,
    output logic                  stall_od
);
    localparam int NENT = 2 * NST;
    localparam int NOP  = 2 * NSRC;

    logic [NENT-1:0]    ord_live;
    logic [NENT-1:0]    ord_rdy;
    logic [NENT*RW-1:0] ord_dst;
    logic [NENT*DW-1:0] ord_data;
    logic [NOP-1:0]     pend;

    // Purpose: order entries youngest first; odd at 2s, even at 2s+1.
    for (genvar s = 0; s < NST; s++) begin : g_stage
        fwd_lat_lut #(
            .CW(CW), .LAT1(LAT1), .LAT2(LAT2), .LAT3(LAT3), .LAT4(LAT4),
            .LAT5(LAT5), .LAT6(LAT6), .LAT7(LAT7)
        ) u_lut_od (
            .vld  (od_vld[s]),
            .unit (unit_id_t'(od_unit[s*3 +: 3])),
            .age  (od_age[s*CW +: CW]),
            .live (ord_live[2*s]),
            .rdy  (ord_rdy[2*s])
        );
        fwd_lat_lut #(
            .CW(CW), .LAT1(LAT1), .LAT2(LAT2), .LAT3(LAT3), .LAT4(LAT4),
            .LAT5(LAT5), .LAT6(LAT6), .LAT7(LAT7)
        ) u_lut_ev (
            .vld  (ev_vld[s]),
            .unit (unit_id_t'(ev_unit[s*3 +: 3])),
            .age  (ev_age[s*CW +: CW]),
            .live (ord_live[2*s+1]),
            .rdy  (ord_rdy[2*s+1])
        );
        assign ord_dst [(2*s)*RW   +: RW] = od_dst [s*RW +: RW];
        assign ord_dst [(2*s+1)*RW +: RW] = ev_dst [s*RW +: RW];
        assign ord_data[(2*s)*DW   +: DW] = od_data[s*DW +: DW];
        assign ord_data[(2*s+1)*DW +: DW] = ev_data[s*DW +: DW];
    end

    // Purpose: one selector per operand slot, slots of both pipes alike.
    for (genvar o = 0; o < NOP; o++) begin : g_opnd
        fwd_pick #(.NENT(NENT), .RW(RW), .DW(DW)) u_pick (
            .live (ord_live),
            .rdy  (ord_rdy),
            .dst  (ord_dst),
            .data (ord_data),
            .src  (src_addr[o*RW +: RW]),
            .rf   (rf_data[o*DW +: DW]),
            .opnd (opnd[o*DW +: DW]),
            .pend (pend[o])
        );
    end

    // Purpose: each pipe stalls only on its own operand slots.
    always_comb begin
        stall_ev = |pend[NSRC-1:0];
        stall_od = |pend[NOP-1:NSRC];
    end
endmodule

// File: tb/sim_fwd_net.sv
// Bench for fwd_net: directed corners plus seeded random vectors against a
// reference model held in bench functions.
module sim_fwd_net;
    localparam int NST  = 7;
    localparam int NSRC = 3;
    localparam int RW   = 7;
    localparam int DW   = 128;
    localparam int CW   = 4;
    localparam int NOP  = 2 * NSRC;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic           ev_v [NST];
    logic [RW-1:0]  ev_d [NST];
    logic [2:0]     ev_u [NST];
    logic [CW-1:0]  ev_a [NST];
    logic [DW-1:0]  ev_x [NST];
    logic           od_v [NST];
    logic [RW-1:0]  od_d [NST];
    logic [2:0]     od_u [NST];
    logic [CW-1:0]  od_a [NST];
    logic [DW-1:0]  od_x [NST];
    logic [RW-1:0]  src  [NOP];
    logic [DW-1:0]  rfv  [NOP];

    logic [NST-1:0]       ev_vld, od_vld;
    logic [NST*RW-1:0]    ev_dst, od_dst;
    logic [NST*3-1:0]     ev_unit, od_unit;
    logic [NST*CW-1:0]    ev_age, od_age;
    logic [NST*DW-1:0]    ev_data, od_data;
    logic [NOP*RW-1:0]    src_addr;
    logic [NOP*DW-1:0]    rf_data;
    logic [NOP*DW-1:0]    opnd;
    logic                 stall_ev, stall_od;

    always_comb begin
        for (int s = 0; s < NST; s++) begin
            ev_vld[s] = ev_v[s];  od_vld[s] = od_v[s];
            ev_dst[s*RW +: RW] = ev_d[s];  od_dst[s*RW +: RW] = od_d[s];
            ev_unit[s*3 +: 3] = ev_u[s];   od_unit[s*3 +: 3] = od_u[s];
            ev_age[s*CW +: CW] = ev_a[s];  od_age[s*CW +: CW] = od_a[s];
            ev_data[s*DW +: DW] = ev_x[s]; od_data[s*DW +: DW] = od_x[s];
        end
        for (int o = 0; o < NOP; o++) begin
            src_addr[o*RW +: RW] = src[o];
            rf_data[o*DW +: DW]  = rfv[o];
        end
    end

    fwd_net u0 (
        .ev_vld(ev_vld), .ev_dst(ev_dst), .ev_unit(ev_unit), .ev_age(ev_age), .ev_data(ev_data),
        .od_vld(od_vld), .od_dst(od_dst), .od_unit(od_unit), .od_age(od_age), .od_data(od_data),
        .src_addr(src_addr), .rf_data(rf_data), .opnd(opnd),
        .stall_ev(stall_ev), .stall_od(stall_od)
    );

    int vectors = 0;
    int fails   = 0;

    // Reference latency per unit (R3).
    function automatic int ref_lat(input logic [2:0] u);
        case (u)
            3'd1: return 2;  3'd2: return 4;  3'd3: return 6;  3'd4: return 4;
            3'd5: return 4;  3'd6: return 6;  3'd7: return 7;
            default: return 0;
        endcase
    endfunction

    function automatic logic [DW-1:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    // Reference choice: lowest age key wins; key = 2*stage, +1 for the even pipe.
    function automatic void ref_pick(input int o, output logic [DW-1:0] e_op, output logic e_pend);
        int best = 1000;
        logic [DW-1:0] bdat = '0;
        logic brdy = 1'b0;
        for (int s = 0; s < NST; s++) begin
            if (od_v[s] && od_u[s] != 0 && od_d[s] == src[o] && 2*s < best) begin
                best = 2*s; bdat = od_x[s]; brdy = int'(od_a[s]) >= ref_lat(od_u[s]);
            end
            if (ev_v[s] && ev_u[s] != 0 && ev_d[s] == src[o] && 2*s+1 < best) begin
                best = 2*s+1; bdat = ev_x[s]; brdy = int'(ev_a[s]) >= ref_lat(ev_u[s]);
            end
        end
        if (best == 1000) begin e_op = rfv[o]; e_pend = 1'b0; end
        else if (brdy)    begin e_op = bdat;   e_pend = 1'b0; end
        else              begin e_op = rfv[o]; e_pend = 1'b1; end
    endfunction

    task automatic check_all(input string tag);
        logic [DW-1:0] e_op;
        logic e_pend;
        logic e_sev = 1'b0;
        logic e_sod = 1'b0;
        vectors++;
        for (int o = 0; o < NOP; o++) begin
            ref_pick(o, e_op, e_pend);
            if (o < NSRC) e_sev |= e_pend; else e_sod |= e_pend;
            if (opnd[o*DW +: DW] !== e_op) begin
                fails++;
                $display("FAIL %s slot %0d operand: got %h expected %h", tag, o, opnd[o*DW +: DW], e_op);
            end
        end
        if (stall_ev !== e_sev) begin
            fails++;
            $display("FAIL %s R8 stall_ev: got %b expected %b", tag, stall_ev, e_sev);
        end
        if (stall_od !== e_sod) begin
            fails++;
            $display("FAIL %s R8 stall_od: got %b expected %b", tag, stall_od, e_sod);
        end
    endtask

    task automatic clr();
        for (int s = 0; s < NST; s++) begin
            ev_v[s] = 0; ev_d[s] = 0; ev_u[s] = 0; ev_a[s] = 0; ev_x[s] = rnd128();
            od_v[s] = 0; od_d[s] = 0; od_u[s] = 0; od_a[s] = 0; od_x[s] = rnd128();
        end
        for (int o = 0; o < NOP; o++) begin src[o] = 7'd127; rfv[o] = rnd128(); end
    endtask

    task automatic rnd_fill();
        for (int s = 0; s < NST; s++) begin
            ev_v[s] = 1'($urandom_range(0, 1)); ev_d[s] = RW'($urandom_range(0, 3));
            ev_u[s] = 3'($urandom_range(0, 7)); ev_a[s] = CW'($urandom_range(0, 9));
            ev_x[s] = rnd128();
            od_v[s] = 1'($urandom_range(0, 1)); od_d[s] = RW'($urandom_range(0, 3));
            od_u[s] = 3'($urandom_range(0, 7)); od_a[s] = CW'($urandom_range(0, 9));
            od_x[s] = rnd128();
        end
        for (int o = 0; o < NOP; o++) begin
            src[o] = RW'($urandom_range(0, 4)); rfv[o] = rnd128();
        end
    endtask

    // Apply the vector set at the falling edge, compare 1 ns later.
    task automatic step(input string tag);
        #1 check_all(tag);
        @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 200000) begin
                fails++;
                $display("FAIL watchdog expired: got %0d cycles expected under 200000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5eed_0545));
        @(negedge clk);

        // R6: idle pipes, every operand from the register file, no stall.
        clr(); step("R6 idle");

        // R3: simple fixed-point result, age 1 stalls, age 2 forwards.
        clr(); ev_v[0] = 1; ev_u[0] = 1; ev_d[0] = 5; ev_a[0] = 1; src[0] = 5; src[4] = 5;
        step("R3 add-word age1");
        ev_a[0] = 2; step("R3 add-word age2");
        if (opnd[0 +: DW] !== ev_x[0]) begin
            fails++; $display("FAIL R3 direct: got %h expected %h", opnd[0 +: DW], ev_x[0]);
        end

        // R3: every unit one below and at its latency, in both pipes.
        for (int u = 1; u <= 7; u++) begin
            for (int d = -1; d <= 0; d++) begin
                clr();
                od_v[3] = 1; od_u[3] = 3'(u); od_d[3] = 7'd40; od_a[3] = CW'(ref_lat(3'(u)) + d);
                ev_v[5] = 1; ev_u[5] = 3'(u); ev_d[5] = 7'd41; ev_a[5] = CW'(ref_lat(3'(u)) + d);
                src[1] = 7'd40; src[3] = 7'd41; src[5] = 7'd40;
                step("R3 unit boundary R2 cross-pipe");
            end
        end

        // R4: same stage, odd entry is younger than even entry.
        clr(); ev_v[2] = 1; ev_u[2] = 1; ev_d[2] = 9; ev_a[2] = 5;
        od_v[2] = 1; od_u[2] = 2; od_d[2] = 9; od_a[2] = 5; src[0] = 9; src[4] = 9;
        step("R4 same stage");
        if (opnd[4*DW +: DW] !== od_x[2]) begin
            fails++; $display("FAIL R4 direct: got %h expected %h", opnd[4*DW +: DW], od_x[2]);
        end
        // R4: lower stage beats higher stage across pipes.
        clr(); od_v[4] = 1; od_u[4] = 1; od_d[4] = 9; od_a[4] = 6;
        ev_v[1] = 1; ev_u[1] = 1; ev_d[1] = 9; ev_a[1] = 3; src[2] = 9;
        step("R4 stage order");

        // R5: young unready match shadows an older ready one.
        clr(); ev_v[0] = 1; ev_u[0] = 3; ev_d[0] = 12; ev_a[0] = 0;
        od_v[5] = 1; od_u[5] = 1; od_d[5] = 12; od_a[5] = 7; src[1] = 12;
        step("R5 shadow");
        if (stall_ev !== 1'b1 || opnd[1*DW +: DW] !== rfv[1]) begin
            fails++; $display("FAIL R5 direct: got %b/%h expected 1/%h", stall_ev, opnd[1*DW +: DW], rfv[1]);
        end

        // R7: register 0 forwarded with an all-ones value.
        clr(); od_v[1] = 1; od_u[1] = 6; od_d[1] = 0; od_a[1] = 6; od_x[1] = '1; src[3] = 0;
        step("R7 reg0");

        // R1: valid entry with unit 0, and invalid entry with a unit, both ignored.
        clr(); ev_v[0] = 1; ev_u[0] = 0; ev_d[0] = 20; ev_a[0] = 9;
        od_v[0] = 0; od_u[0] = 1; od_d[0] = 20; od_a[0] = 9; src[2] = 20; src[5] = 20;
        step("R1 empty slots");

        // R8: only an odd slot pending, even pipe must not stall.
        clr(); od_v[2] = 1; od_u[2] = 7; od_d[2] = 33; od_a[2] = 2; src[4] = 33;
        step("R8 odd only");

        // R2 R4 R5: seeded random vectors with dense register overlap.
        for (int n = 0; n < 3000; n++) begin
            rnd_fill();
            step("R2 R4 R5 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule